// File: doc/BRIEF.md
# Serial 0-0-1 Pattern Recognizer with Mealy and Moore Outputs

This block watches a single serial input `x`, one bit per clock, and flags every place where the bit stream shows a 0, then another 0, then a 1. It contains two independent recognizers for the same pattern. Both outputs come from the top module.

The Mealy machine keeps three states in a two-bit register. Its flag `y_mealy` is formed from the present state and the live input. It rises in the same cycle that the final 1 is presented.

The Moore machine uses a fourth state that is entered only after a match. Its flag `y_moore` is decoded from the state register alone. It therefore rises one clock later and holds steady for the whole cycle.

A designer can tap whichever output suits the timing around it. The Mealy flag has zero latency but a combinational path from `x`. The Moore flag has one cycle of latency and is clean for a whole cycle. Both machines return to their idle state on a synchronous, active-high reset.

Top module: `seq001_recognizer`

## Requirements
- R1: `y_mealy` is 1 in a cycle exactly when the two inputs clocked in since reset just before that cycle were 0 and 0 (oldest first) and the present `x` is 1. Otherwise it is 0.
- R2: Runs of zeros are tracked with overlap. Any run of two or more zeros that is followed by a 1 produces exactly one match, on that 1.
- R3: An input of 1 discards all progress. After a 1, the next match needs two further zeros and then a 1. For example, 0,1,0,1 never matches and 1,0,0,1 matches on its last bit.
- R4: `y_moore` in every cycle after reset equals the value `y_mealy` had in the previous cycle.
- R5: `y_moore` depends only on stored state. Changing `x` within a cycle never changes `y_moore` in that cycle.
- R6: Each match raises `y_moore` for exactly one cycle. This holds even when matches come back to back. In 0,0,1,0,0,1 the zero after the first match counts toward the second match, which falls on the sixth bit.
- R7: Reset is synchronous and active high. After a clock edge with `rst` at 1, both flags are 0 and all earlier input history is forgotten. For example, 0,0 then reset then 1 is not a match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of both machines |
| x | input | 1 | Serial data bit, one per clock |
| y_mealy | output | 1 | Mealy match flag, same cycle as the final 1 |
| y_moore | output | 1 | Moore match flag, one cycle after the final 1 |

## Verification
On every cycle, the embedded assertions check four things:
- a Mealy match is always preceded by two zeros;
- a 1 always drops the Mealy machine back to idle;
- the Moore state holds on repeated zeros and its flag never lasts two cycles;
- the Moore flag is the Mealy flag delayed by one clock, and reset clears both flags.

Other properties need the bench's scenarios. These include the absence of false or missed matches across whole streams, the reuse of the zero after a match, and the loss of history across a mid-pattern reset. The bench also toggles `x` inside each cycle to show that `y_moore` does not follow the input.

// File: rtl/seq001_pkg.sv
package seq001_pkg;

  localparam int unsigned STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'b00,
    ST_ONE0 = 2'b01,
    ST_TWO0 = 2'b10,
    ST_HIT  = 2'b11
  } rec_state_t;

  localparam logic [STATE_W-1:0] MEALY_UNUSED = 2'b11;

endpackage

// File: rtl/seq001_mealy.sv
module seq001_mealy
  import seq001_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic y
);

  logic [STATE_W-1:0] q;
  logic [STATE_W-1:0] q_nxt;
  logic               d1;
  logic               d0;

  // Next-state equations for the three-state machine (00, 01, 10).
  always_comb begin
    d1 = ~x & (q[0] | q[1]);
    d0 = ~q[1] & ~q[0] & ~x;
    if (q == MEALY_UNUSED) q_nxt = ST_IDLE;
    else                   q_nxt = {d1, d0};
  end

  always_ff @(posedge clk) begin
    if (rst) q <= ST_IDLE;
    else     q <= q_nxt;
  end

  // Match when two zeros have been seen and the present bit is 1.
  assign y = q[1] & ~q[0] & x;

  AST_MEALY_MATCH: assert property (@(posedge clk) disable iff (rst)
    y |-> (x && !$past(x) && !$past(x, 2))); // R1

  AST_MEALY_ONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    x |=> (q == ST_IDLE)); // R3

endmodule

// File: rtl/seq001_moore.sv
module seq001_moore
  import seq001_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic y
);

  rec_state_t st;
  rec_state_t st_nxt;

  always_comb begin
    unique case (st)
      ST_IDLE: st_nxt = x ? ST_IDLE : ST_ONE0;
      ST_ONE0: st_nxt = x ? ST_IDLE : ST_TWO0;
      ST_TWO0: st_nxt = x ? ST_HIT  : ST_TWO0;
      ST_HIT:  st_nxt = x ? ST_IDLE : ST_ONE0;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nxt;
  end

  // Output is decoded from the register only.
  assign y = (st == ST_HIT);

  AST_MOORE_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TWO0 && !x) |=> (st == ST_TWO0)); // R2

  AST_MOORE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    y |=> !y); // R6

endmodule

// File: rtl/seq001_recognizer.sv
module seq001_recognizer
  import seq001_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic y_mealy,
  output logic y_moore
);

  seq001_mealy u_mealy (
    .clk (clk),
    .rst (rst),
    .x   (x),
    .y   (y_mealy)
  );

  seq001_moore u_moore (
    .clk (clk),
    .rst (rst),
    .x   (x),
    .y   (y_moore)
  );

  AST_MOORE_LAG: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (y_moore == $past(y_mealy))); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!y_moore && !y_mealy)); // R7

endmodule

// File: tb/seq001_recognizer_bench.sv
module seq001_recognizer_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x   = 1'b0;
  logic y_mealy;
  logic y_moore;

  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 1'b0;

  logic hist[$];
  logic prev_mealy = 1'b0;

  always #2.5 clk = ~clk;

  seq001_recognizer u_seq001_recognizer (
    .clk     (clk),
    .rst     (rst),
    .x       (x),
    .y_mealy (y_mealy),
    .y_moore (y_moore)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One input bit. The bench sets the opposite value first, then the real one,
  // to show the Moore flag ignores x inside the cycle.
  task automatic step(input logic xv, input string mtag, input string otag);
    logic exp_m;
    logic moore_a;
    int   n;
    @(negedge clk);
    x = ~xv;
    #0.5;
    moore_a = y_moore;
    x = xv;
    #0.5;
    check("R5 moore stable within cycle", y_moore, moore_a);
    n = hist.size();
    exp_m = (n >= 2) && (hist[n-1] == 1'b0) && (hist[n-2] == 1'b0) && xv;
    check(mtag, y_mealy, exp_m);
    check(otag, y_moore, prev_mealy);
    @(posedge clk);
    hist.push_back(xv);
    if (hist.size() > 3) void'(hist.pop_front());
    prev_mealy = exp_m;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    x   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    check("R7 mealy clear after reset", y_mealy, 1'b0);
    check("R7 moore clear after reset", y_moore, 1'b0);
    hist.delete();
    prev_mealy = 1'b0;
  endtask

  task automatic seq(input logic [15:0] bits, input int len, input string mtag, input string otag);
    for (int i = len - 1; i >= 0; i--) step(bits[i], mtag, otag);
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (2) @(posedge clk);
    do_reset();
    seq(16'b001, 3, "R1 basic 001", "R4 basic 001");
    seq(16'b0001, 4, "R2 three zeros then 1", "R4 three zeros");
    seq(16'b000001, 6, "R2 long zero run", "R4 long zero run");
    seq(16'b0101, 4, "R3 0101 no match", "R4 0101");
    seq(16'b1001, 4, "R3 1001 match", "R4 1001");
    seq(16'b0110011, 7, "R3 ones then 0011", "R6 single pulse after 0011");
    seq(16'b001001, 6, "R6 back to back mealy", "R6 back to back moore");
    seq(16'b00, 2, "R1 prefix", "R4 prefix");
    do_reset();
    seq(16'b1, 1, "R7 history lost on reset", "R7 moore after reset");
    seq(16'b0010, 4, "R1 after reset", "R4 after reset");
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      step(lfsr[0] & lfsr[3], "R1 random stream", "R4 random stream");
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule